// File: doc/BRIEF.md
# Three-Modulus Prescaler Sequencer

This block is the digital counter behind an RF prescaler that can divide by 64, 65 or 72. It is clocked by the prescaler output, so one clock period equals one prescaler cycle. For every prescaler cycle it tells the prescaler which ratio to use. A main divider cycle runs three phases in a fixed order: a programmed number of cycles at 64, then at 65, then at 72. When the last prescaler cycle of a main cycle is under way, the block raises a done pulse. That pulse drives the main phase comparator.

Software writes the three counts and a 72-enable bit into a shadow bank through a write strobe. The running sequence only takes these values at a main-cycle boundary, so a reprogrammed ratio never breaks a cycle that is in progress. A fractional accumulator can ask for one extra input count in a cycle. The block does this by turning one divide-by-64 cycle into a divide-by-65 cycle. An enable input holds the divider idle. When the enable is raised, the divider starts a fresh cycle from the current shadow values.

Top module: `tpm_divider_ctrl`

## Requirements
- R1: `mod_sel_o` uses code 0 for ratio 64, 1 for ratio 65 and 2 for ratio 72, and never shows code 3. Inside one main cycle the code never decreases: all 64 cycles come first, then all 65 cycles, then all 72 cycles.
- R2: In each main cycle the number of prescaler cycles at each ratio equals the count loaded for that phase. A phase whose count is zero does not appear.
- R3: `done_o` is high for exactly the last prescaler cycle of each main cycle. The input cycles covered by one main cycle total 64·A + 65·B + 72·C, where A, B and C are the loaded phase counts.
- R4: `frac_i` is sampled on the clock edge that starts a main cycle. If it is high and the 64 count is nonzero, that cycle has one cycle fewer at 64 and one more at 65, which adds one to its division. If the 64 count is zero, the request is ignored.
- R5: When `use72_i` was written as 0, the 72 count is ignored and no 72 cycle appears.
- R6: `wr_i` copies the four programming inputs into the shadow bank at the clock edge. A main cycle takes its values from the shadow bank as it stood just before its starting edge, so a write on that edge only affects the cycle after.
- R7: While the registered enable is low, `mod_sel_o` is 0 and `done_o` is 0. The first edge that samples `en_i` high starts a new main cycle from the shadow bank.
- R8: If all loaded counts are zero, every prescaler cycle is a complete main cycle at ratio 64, with `done_o` high on each one.
- R9: Reset clears the shadow bank to zero and leaves the outputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock, one period per prescaler cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable |
| wr_i | input | 1 | Shadow bank write strobe |
| cnt64_i | input | 12 | Prescaler cycles at ratio 64 |
| cnt65_i | input | 12 | Prescaler cycles at ratio 65 |
| cnt72_i | input | 12 | Prescaler cycles at ratio 72 |
| use72_i | input | 1 | Enables the 72 phase |
| frac_i | input | 1 | Fraction request for the next main cycle |
| mod_sel_o | output | 2 | Ratio code for the current prescaler cycle |
| done_o | output | 1 | Last prescaler cycle of a main cycle |

## Verification
Every output is registered, so the ratio code and done flag for a prescaler cycle belong to the state loaded on the clock edge that began that cycle. The bench reads them at the following falling edge and drives new inputs right after that read. A write, a fraction request or an enable change that the bench drives at one falling edge therefore takes effect at the very next rising edge. It affects results from the following falling-edge sample on. The bench model applies each stimulus with exactly that one-edge delay. It builds the expected per-phase counts at the reload edge, using the shadow values as they stood before any write on that same edge, and checks them when the done flag appears.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic [1:0] {
    MS_64 = 2'd0,
    MS_65 = 2'd1,
    MS_72 = 2'd2
  } mod_e;
endpackage

// File: rtl/tpm_prog_shadow.sv
module tpm_prog_shadow #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  input  logic [CNT_W-1:0] c_i,
  input  logic             use_c_i,
  output logic [CNT_W-1:0] a_o,
  output logic [CNT_W-1:0] b_o,
  output logic [CNT_W-1:0] c_o,
  output logic             use_c_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o     <= '0;
      b_o     <= '0;
      c_o     <= '0;
      use_c_o <= 1'b0;
    end else if (wr_i) begin
      a_o     <= a_i;
      b_o     <= b_i;
      c_o     <= c_i;
      use_c_o <= use_c_i;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({a_o, b_o, c_o, use_c_o})); // R6
endmodule

// File: rtl/tpm_frac_adjust.sv
module tpm_frac_adjust #(
  parameter int CNT_W = 12,
  localparam int WRK_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  input  logic [CNT_W-1:0] c_i,
  input  logic             use_c_i,
  input  logic             frac_i,
  output logic [WRK_W-1:0] a_o,
  output logic [WRK_W-1:0] b_o,
  output logic [WRK_W-1:0] c_o
);
  always_comb begin
    a_o = {1'b0, a_i};
    b_o = {1'b0, b_i};
    c_o = use_c_i ? {1'b0, c_i} : '0;
    // move one 64 cycle into the 65 phase: +1 input count
    if (frac_i && (a_i != '0)) begin
      a_o = a_o - 1'b1;
      b_o = b_o + 1'b1;
    end
  end
endmodule

// File: rtl/tpm_mod_seq.sv
module tpm_mod_seq
  import tpm_pkg::*;
#(
  parameter int CNT_W = 12,
  localparam int WRK_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WRK_W-1:0] ld_a_i,
  input  logic [WRK_W-1:0] ld_b_i,
  input  logic [WRK_W-1:0] ld_c_i,
  output mod_e             mod_sel_o,
  output logic             done_o
);
  logic             en_q;
  mod_e             ph_q, ph_n;
  logic [WRK_W-1:0] cnt_q, cnt_n, cnt_dec;
  logic [WRK_W-1:0] b_q, b_n, c_q, c_n;
  logic             ph_end, more_b, more_c, last, reload;

  assign cnt_dec = cnt_q - 1'b1;
  assign ph_end  = cnt_dec[WRK_W-1];  // sign bit: phase exhausted
  assign more_b  = (ph_q == MS_64) && (b_q != '0);
  assign more_c  = (ph_q != MS_72) && (c_q != '0);
  assign last    = ph_end && !more_b && !more_c;
  assign reload  = !en_q || last;

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_dec;
    b_n   = b_q;
    c_n   = c_q;
    if (reload) begin
      b_n = ld_b_i;
      c_n = ld_c_i;
      if (ld_a_i != '0) begin
        ph_n  = MS_64;
        cnt_n = ld_a_i - 1'b1;
      end else if (ld_b_i != '0) begin
        ph_n  = MS_65;
        cnt_n = ld_b_i - 1'b1;
      end else if (ld_c_i != '0) begin
        ph_n  = MS_72;
        cnt_n = ld_c_i - 1'b1;
      end else begin
        ph_n  = MS_64;
        cnt_n = '0;
      end
    end else if (ph_end) begin
      if (more_b) begin
        ph_n  = MS_65;
        cnt_n = b_q - 1'b1;
      end else begin
        ph_n  = MS_72;
        cnt_n = c_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ph_q  <= MS_64;
      cnt_q <= '0;
      b_q   <= '0;
      c_q   <= '0;
    end else begin
      en_q  <= en_i;
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      b_q   <= b_n;
      c_q   <= c_n;
    end
  end

  assign mod_sel_o = en_q ? ph_q : MS_64;
  assign done_o    = en_q && last;

  AST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !last) |=> (ph_q >= $past(ph_q))); // R1
  AST_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !ph_end) |=> (ph_q == $past(ph_q))); // R2
  AST_SKIP_65: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == MS_65) |-> (b_q != '0)); // R2
  AST_SKIP_72: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == MS_72) |-> (c_q != '0)); // R5
endmodule

// File: rtl/tpm_divider_ctrl.sv
module tpm_divider_ctrl
  import tpm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] cnt64_i,
  input  logic [CNT_W-1:0] cnt65_i,
  input  logic [CNT_W-1:0] cnt72_i,
  input  logic             use72_i,
  input  logic             frac_i,
  output logic [1:0]       mod_sel_o,
  output logic             done_o
);
  localparam int WRK_W = CNT_W + 1;

  logic [CNT_W-1:0] sh_a, sh_b, sh_c;
  logic             sh_use_c;
  logic [WRK_W-1:0] ld_a, ld_b, ld_c;
  mod_e             mod_sel;

  tpm_prog_shadow #(.CNT_W(CNT_W)) i_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .a_i     (cnt64_i),
    .b_i     (cnt65_i),
    .c_i     (cnt72_i),
    .use_c_i (use72_i),
    .a_o     (sh_a),
    .b_o     (sh_b),
    .c_o     (sh_c),
    .use_c_o (sh_use_c)
  );

  tpm_frac_adjust #(.CNT_W(CNT_W)) i_frac (
    .a_i     (sh_a),
    .b_i     (sh_b),
    .c_i     (sh_c),
    .use_c_i (sh_use_c),
    .frac_i  (frac_i),
    .a_o     (ld_a),
    .b_o     (ld_b),
    .c_o     (ld_c)
  );

  tpm_mod_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ld_a_i    (ld_a),
    .ld_b_i    (ld_b),
    .ld_c_i    (ld_c),
    .mod_sel_o (mod_sel),
    .done_o    (done_o)
  );

  assign mod_sel_o = mod_sel;
endmodule

// File: tb/test_tpm_divider_ctrl.sv
`timescale 1ns/1ps
module test_tpm_divider_ctrl;
  localparam int CNT_W = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             wr_i = 1'b0;
  logic [CNT_W-1:0] cnt64_i = '0;
  logic [CNT_W-1:0] cnt65_i = '0;
  logic [CNT_W-1:0] cnt72_i = '0;
  logic             use72_i = 1'b0;
  logic             frac_i = 1'b0;
  logic [1:0]       mod_sel_o;
  logic             done_o;

  always #2 clk_i = ~clk_i;

  tpm_divider_ctrl #(.CNT_W(CNT_W)) i_tpm_divider_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_i      (wr_i),
    .cnt64_i   (cnt64_i),
    .cnt65_i   (cnt65_i),
    .cnt72_i   (cnt72_i),
    .use72_i   (use72_i),
    .frac_i    (frac_i),
    .mod_sel_o (mod_sel_o),
    .done_o    (done_o)
  );

  int checks = 0, fails = 0;
  bit ended = 0;
  int sh_a = 0, sh_b = 0, sh_c = 0;
  bit sh_pr = 0;
  int ea = 1, eb = 0, ec = 0;
  int n64 = 0, n65 = 0, n72 = 0, last_code = 0;
  bit bad_order = 0, en_prev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected phase counts for a cycle starting from the shadow bank
  task automatic plan_cycle(input bit fr);
    ea = sh_a;
    eb = sh_b;
    ec = sh_pr ? sh_c : 0;
    if (fr && ea > 0) begin
      ea--;
      eb++;
    end
    if (ea == 0 && eb == 0 && ec == 0) ea = 1;
    n64 = 0; n65 = 0; n72 = 0; last_code = 0; bad_order = 0;
  endtask

  task automatic step(input bit en_v, input bit wr_v, input int a, input int b,
                      input int c, input bit pr, input bit fr);
    bit reload;
    @(negedge clk_i);
    if (en_prev) begin
      if (mod_sel_o == 2'd3) check(0, "R1", "illegal code", 3, 0);
      else begin
        if (int'(mod_sel_o) < last_code) bad_order = 1;
        last_code = int'(mod_sel_o);
        case (mod_sel_o)
          2'd0: n64++;
          2'd1: n65++;
          default: n72++;
        endcase
      end
      if (done_o) begin
        check(n64 == ea, "R2 R4 R8 R9", "count64", n64, ea);
        check(n65 == eb, "R2 R4 R6", "count65", n65, eb);
        check(n72 == ec, "R2 R5 R6", "count72", n72, ec);
        check(!bad_order, "R1", "order violations", int'(bad_order), 0);
        check(64*n64 + 65*n65 + 72*n72 == 64*ea + 65*eb + 72*ec, "R3",
              "input cycles", 64*n64 + 65*n65 + 72*n72, 64*ea + 65*eb + 72*ec);
      end
    end else begin
      check(mod_sel_o == 2'd0 && !done_o, "R7", "idle outputs",
            int'({mod_sel_o, done_o}), 0);
    end
    reload = !en_prev || (done_o === 1'b1);
    en_i    = en_v;
    wr_i    = wr_v;
    cnt64_i = CNT_W'(a);
    cnt65_i = CNT_W'(b);
    cnt72_i = CNT_W'(c);
    use72_i = pr;
    frac_i  = fr;
    if (reload) plan_cycle(fr);
    if (wr_v) begin
      sh_a = a; sh_b = b; sh_c = c; sh_pr = pr;
    end
    en_prev = en_v;
  endtask

  task automatic run(input int n, input bit fr);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, fr);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check(mod_sel_o == 2'd0 && done_o == 1'b0, "R9", "reset outputs",
          int'({mod_sel_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) step(0, 0, 0, 0, 0, 0, 0);
    // shadow is zero after reset: single-cycle main cycles at 64 (R8, R9)
    run(6, 0);
    step(1, 1, 3, 2, 1, 1, 0);
    run(30, 0);
    run(25, 1);                        // R4 fraction with nonzero 64 count
    step(1, 1, 0, 4, 2, 1, 1);
    run(25, 1);                        // R4 ignored when 64 count is zero
    step(1, 1, 2, 1, 5, 0, 0);
    run(25, 0);                        // R5 72 phase disabled
    step(1, 1, 1, 0, 3, 1, 0);
    run(4, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0); // R7 disable mid-cycle
    run(20, 0);
    step(1, 1, 4095, 4095, 7, 1, 1);   // widest counts, fraction pushes 65 past 12 bits
    run(16500, 1);
    for (int i = 0; i < 4000; i++) begin
      bit en_v = ($urandom % 40) != 0;
      bit wr_v = ($urandom % 8) == 0;
      step(en_v, wr_v, $urandom % 6, $urandom % 6, $urandom % 6,
           ($urandom % 4) != 0, ($urandom % 3) == 0);
    end
    run(40, 0);
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule